// File: doc/BRIEF.md
# Multi-Level Block-Aware Translation Cache

This block is a fully associative translation cache for an I/O memory management unit. Each entry maps one naturally aligned block of input address space to a block of output address space. The block can be a small page or a large block, and its size depends on the translation granule and on the level at which the mapping was found. Each entry carries an address-space identifier (ASID), a granule code, a level, an aligned input base, an aligned output base and read/write permissions.

A lookup gives an ASID, an input address, a granule code and the input-size field. The cache first computes the coarsest level that the given input size allows. It then probes one level per clock cycle, moving toward level 3. At each level it aligns the address to that level's block size and compares the full tag. The first level that hits ends the search, and a miss is reported only after level 3 has been probed.

Entries are written through an insert port. Three maintenance ports remove entries:
- flush everything;
- flush one ASID;
- flush by address, where the ASID can be given or set to "any".

Two counters record table hits and misses.

The lookup engine is a three-state machine:
- **S_IDLE** goes to **S_PROBE** when a request is accepted. The starting level is latched at that point.
- **S_PROBE** stays in S_PROBE and moves one level finer on a miss below level 3.
- **S_PROBE** goes to **S_REPORT** on a tag hit, or on a miss at level 3.
- **S_REPORT** drives the one-cycle done strobe and always returns to **S_IDLE**.

Top module: `iotlb_top`

## Requirements
- R1: A probe hits only when an entry is valid and all four tag parts are equal: its ASID, its granule code, its level, and its input base compared with the lookup address aligned to that level's block size.
- R2: Granule code 1, 2 and 3 select a 4 KB, 16 KB and 64 KB granule, so g = 10 + 2·code. The block size at level L is 2^(g + (g−3)·(3−L)). A block of 2^48 bytes or more covers the whole 48-bit input space.
- R3: The first level probed is 4 − (60 − TSZ) / (g − 3), using integer division and clamped to 0..3. Levels coarser than this are never probed, even when an entry there would match.
- R4: Probing takes one cycle per level. If a request is accepted at a clock edge and the search ends after n probes, lk_done is high for exactly one cycle, in the cycle after the n-th following edge. The first level that hits ends the search.
- R5: On a hit, lk_hit is 1, lk_out_addr equals the entry's output base plus (address AND block mask), and lk_perm returns the entry's permissions (bit 0 = read, bit 1 = write).
- R6: A write lookup (lk_write = 1) that hits an entry whose write bit is 0 returns lk_fault = 1, lk_hit = 0 and lk_out_addr = 0.
- R7: If no level up to and including level 3 hits, the result is a miss: lk_hit = 0 and lk_fault = 0.
- R8: An insert that arrives when every slot is valid first flushes the whole table and then writes the new entry. Only that entry remains.
- R9: An address flush removes every entry whose ASID matches, or any entry when the wildcard flag is set, and whose input base equals (address AND NOT entry mask). All other entries stay.
- R10: An ASID flush removes every entry with that ASID and no other entry.
- R11: A full flush clears every entry in one cycle.
- R12: hit_cnt counts lookups that found a matching entry, including faults. miss_cnt counts misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request, taken when lk_busy is 0 |
| lk_asid | input | 16 | Lookup ASID |
| lk_addr | input | 48 | Lookup input address |
| lk_gran | input | 2 | Lookup granule code |
| lk_tsz | input | 6 | Input-size field |
| lk_write | input | 1 | Lookup is a write access |
| lk_busy | output | 1 | Lookup in progress |
| lk_done | output | 1 | One-cycle result strobe |
| lk_hit | output | 1 | Translation returned |
| lk_fault | output | 1 | Write to an entry without write permission |
| lk_out_addr | output | 48 | Translated address |
| lk_perm | output | 2 | Entry permissions |
| ins_valid | input | 1 | Insert strobe |
| ins_asid | input | 16 | Insert ASID |
| ins_in_base | input | 48 | Insert input base |
| ins_out_base | input | 48 | Insert output base |
| ins_gran | input | 2 | Insert granule code |
| ins_level | input | 2 | Insert level |
| ins_perm | input | 2 | Insert permissions |
| inv_all | input | 1 | Flush everything |
| inv_asid_en | input | 1 | Flush by ASID |
| inv_asid | input | 16 | ASID for the ASID flush |
| inv_va_en | input | 1 | Flush by address |
| inv_va_any | input | 1 | Address flush applies to any ASID |
| inv_va_asid | input | 16 | ASID for the address flush |
| inv_va_addr | input | 48 | Address for the address flush |
| hit_cnt | output | 16 | Hit counter |
| miss_cnt | output | 16 | Miss counter |

## Verification
The bench places blocks at levels 0, 1, 2 and 3 under all three granules.

- **Start level (R3).** It looks up a level-0 block with an input size that starts the search at level 1. A design that ignores the start level would wrongly hit here.
- **Tag parts (R1).** It repeats a lookup with a different granule and with a different ASID. A tag that drops either part would return a false translation.
- **Latency (R4).** It measures the cycle count of every lookup. An engine that probes the wrong number of levels, or skips levels, would show a different latency.
- **Address flush (R9).** It tests containment inside a 2 MB block, a non-matching ASID and the wildcard. A design that compares against the page instead of the block span, or that honours the ASID under the wildcard, would leave stale entries.
- **Capacity (R8).** It overfills the table by one entry. A design that overwrites a slot instead of flushing would still hit old entries.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

    localparam int ASID_W = 16;
    localparam int VA_W   = 48;
    localparam int PA_W   = 48;

    typedef logic [1:0] gran_t;
    typedef logic [1:0] lvl_t;
    typedef logic [1:0] perm_t;

    // log2 of block size for a granule code at a level
    function automatic logic [5:0] blk_shift(input gran_t g, input lvl_t l);
        int gs;
        int st;
        gs = 10 + 2 * int'(g);
        st = gs - 3;
        return 6'(gs + st * (3 - int'(l)));
    endfunction

    function automatic logic [VA_W-1:0] blk_mask(input gran_t g, input lvl_t l);
        logic [5:0] sh;
        sh = blk_shift(g, l);
        if (int'(sh) >= VA_W) begin
            return '1;
        end
        return (VA_W'(1) << sh) - VA_W'(1);
    endfunction

    // coarsest level the input size allows, clamped to 0..3
    function automatic lvl_t first_level(input gran_t g, input logic [5:0] tsz);
        int isz;
        int st;
        int s;
        isz = 64 - int'(tsz);
        st  = 7 + 2 * int'(g);
        s   = 4 - (isz - 4) / st;
        if (s < 0) s = 0;
        if (s > 3) s = 3;
        return lvl_t'(s);
    endfunction

endpackage

// File: rtl/iotlb_entry_store.sv
module iotlb_entry_store
    import iotlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [ASID_W-1:0] ins_asid,
    input  logic [VA_W-1:0]   ins_in_base,
    input  logic [PA_W-1:0]   ins_out_base,
    input  gran_t             ins_gran,
    input  lvl_t              ins_level,
    input  perm_t             ins_perm,
    input  logic              inv_all,
    input  logic              inv_asid_en,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic              inv_va_en,
    input  logic              inv_va_any,
    input  logic [ASID_W-1:0] inv_va_asid,
    input  logic [VA_W-1:0]   inv_va_addr,
    input  logic [ASID_W-1:0] probe_asid,
    input  logic [VA_W-1:0]   probe_base,
    input  gran_t             probe_gran,
    input  lvl_t              probe_level,
    output logic              m_any,
    output logic [PA_W-1:0]   m_out_base,
    output perm_t             m_perm
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q;
    logic [ASID_W-1:0]  e_asid [ENTRIES];
    logic [VA_W-1:0]    e_in   [ENTRIES];
    logic [VA_W-1:0]    e_mask [ENTRIES];
    logic [PA_W-1:0]    e_out  [ENTRIES];
    gran_t              e_gran [ENTRIES];
    lvl_t               e_lvl  [ENTRIES];
    perm_t              e_perm [ENTRIES];

    logic [ENTRIES-1:0] probe_hit;
    logic [ENTRIES-1:0] asid_kill;
    logic [ENTRIES-1:0] va_kill;

    generate
        for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
            assign probe_hit[gi] = valid_q[gi]
                                && (e_asid[gi] == probe_asid)
                                && (e_gran[gi] == probe_gran)
                                && (e_lvl[gi]  == probe_level)
                                && (e_in[gi]   == probe_base);
            assign asid_kill[gi] = valid_q[gi] && (e_asid[gi] == inv_asid);
            assign va_kill[gi]   = valid_q[gi]
                                && (inv_va_any || (e_asid[gi] == inv_va_asid))
                                && ((inv_va_addr & ~e_mask[gi]) == e_in[gi]);
        end
    endgenerate

    // lowest matching slot wins
    always_comb begin
        m_any      = 1'b0;
        m_out_base = '0;
        m_perm     = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (probe_hit[i]) begin
                m_any      = 1'b1;
                m_out_base = e_out[i];
                m_perm     = e_perm[i];
            end
        end
    end

    logic              full;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic              ins_take;
    logic [VA_W-1:0]   ins_mask;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) free_idx = IDX_W'(i);
        end
    end

    assign full     = &valid_q;
    assign wr_idx   = full ? '0 : free_idx;
    assign ins_take = ins_valid && !inv_all && !inv_asid_en && !inv_va_en;
    assign ins_mask = blk_mask(ins_gran, ins_level);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (inv_all) begin
            valid_q <= '0;
        end else if (inv_asid_en) begin
            valid_q <= valid_q & ~asid_kill;
        end else if (inv_va_en) begin
            valid_q <= valid_q & ~va_kill;
        end else if (ins_valid) begin
            if (full) begin
                valid_q    <= '0;
                valid_q[0] <= 1'b1;
            end else begin
                valid_q[free_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ins_take) begin
            e_asid[wr_idx] <= ins_asid;
            e_in[wr_idx]   <= ins_in_base & ~ins_mask;
            e_mask[wr_idx] <= ins_mask;
            e_out[wr_idx]  <= ins_out_base & ~PA_W'(ins_mask);
            e_gran[wr_idx] <= ins_gran;
            e_lvl[wr_idx]  <= ins_level;
            e_perm[wr_idx] <= ins_perm;
        end
    end

    a_r11_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_q == '0));

    a_r8_full_insert_leaves_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_take && full) |=> ($countones(valid_q) == 1));

    a_r10_asid_flush_only_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_asid_en && !inv_all) |=> (($past(valid_q) & valid_q) == valid_q));

endmodule

// File: rtl/iotlb_walk_fsm.sv
module iotlb_walk_fsm
    import iotlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_addr,
    input  gran_t             lk_gran,
    input  logic [5:0]        lk_tsz,
    input  logic              lk_write,
    output logic              lk_busy,
    output logic              lk_done,
    output logic              lk_hit,
    output logic              lk_fault,
    output logic [PA_W-1:0]   lk_out_addr,
    output perm_t             lk_perm,
    output logic [ASID_W-1:0] probe_asid,
    output logic [VA_W-1:0]   probe_base,
    output gran_t             probe_gran,
    output lvl_t              probe_level,
    input  logic              m_any,
    input  logic [PA_W-1:0]   m_out_base,
    input  perm_t             m_perm,
    output logic              fin_hit,
    output logic              fin_miss
);

    typedef enum logic [1:0] {S_IDLE, S_PROBE, S_REPORT} walk_state_e;

    walk_state_e state_q;
    walk_state_e state_d;

    logic [ASID_W-1:0] r_asid;
    logic [VA_W-1:0]   r_addr;
    gran_t             r_gran;
    lvl_t              r_lvl;
    logic              r_write;
    logic              res_hit;
    logic              res_fault;
    logic [PA_W-1:0]   res_addr;
    perm_t             res_perm;
    logic [VA_W-1:0]   probe_mask;
    logic              wr_denied;

    assign probe_mask  = blk_mask(r_gran, r_lvl);
    assign probe_asid  = r_asid;
    assign probe_base  = r_addr & ~probe_mask;
    assign probe_gran  = r_gran;
    assign probe_level = r_lvl;
    assign wr_denied   = r_write && !m_perm[1];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (lk_req) state_d = S_PROBE;
            S_PROBE:  if (m_any || (r_lvl == 2'd3)) state_d = S_REPORT;
            S_REPORT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_asid    <= '0;
            r_addr    <= '0;
            r_gran    <= '0;
            r_lvl     <= '0;
            r_write   <= 1'b0;
            res_hit   <= 1'b0;
            res_fault <= 1'b0;
            res_addr  <= '0;
            res_perm  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (lk_req) begin
                    r_asid  <= lk_asid;
                    r_addr  <= lk_addr;
                    r_gran  <= lk_gran;
                    r_write <= lk_write;
                    r_lvl   <= first_level(lk_gran, lk_tsz);
                end
                S_PROBE: begin
                    if (m_any) begin
                        res_hit   <= !wr_denied;
                        res_fault <= wr_denied;
                        res_addr  <= wr_denied ? '0
                                   : m_out_base + PA_W'(r_addr & probe_mask);
                        res_perm  <= m_perm;
                    end else if (r_lvl == 2'd3) begin
                        res_hit   <= 1'b0;
                        res_fault <= 1'b0;
                        res_addr  <= '0;
                        res_perm  <= '0;
                    end else begin
                        r_lvl <= r_lvl + 2'd1;
                    end
                end
                S_REPORT: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        lk_busy     = (state_q != S_IDLE);
        lk_done     = (state_q == S_REPORT);
        lk_hit      = lk_done && res_hit;
        lk_fault    = lk_done && res_fault;
        lk_out_addr = lk_done ? res_addr : '0;
        lk_perm     = lk_done ? res_perm : '0;
        fin_hit     = (state_q == S_PROBE) && m_any;
        fin_miss    = (state_q == S_PROBE) && !m_any && (r_lvl == 2'd3);
    end

    a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |=> !lk_done);

    a_r6_hit_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_fault));

    a_r7_last_level_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PROBE && r_lvl == 2'd3) |=> lk_done);

    a_r4_level_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PROBE && !m_any && r_lvl != 2'd3) |=> (r_lvl == $past(r_lvl) + 2'd1));

endmodule

// File: rtl/iotlb_top.sv
module iotlb_top
    import iotlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_addr,
    input  logic [1:0]        lk_gran,
    input  logic [5:0]        lk_tsz,
    input  logic              lk_write,
    output logic              lk_busy,
    output logic              lk_done,
    output logic              lk_hit,
    output logic              lk_fault,
    output logic [PA_W-1:0]   lk_out_addr,
    output logic [1:0]        lk_perm,
    input  logic              ins_valid,
    input  logic [ASID_W-1:0] ins_asid,
    input  logic [VA_W-1:0]   ins_in_base,
    input  logic [PA_W-1:0]   ins_out_base,
    input  logic [1:0]        ins_gran,
    input  logic [1:0]        ins_level,
    input  logic [1:0]        ins_perm,
    input  logic              inv_all,
    input  logic              inv_asid_en,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic              inv_va_en,
    input  logic              inv_va_any,
    input  logic [ASID_W-1:0] inv_va_asid,
    input  logic [VA_W-1:0]   inv_va_addr,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [CNT_W-1:0]  miss_cnt
);

    logic [ASID_W-1:0] probe_asid;
    logic [VA_W-1:0]   probe_base;
    gran_t             probe_gran;
    lvl_t              probe_level;
    logic              m_any;
    logic [PA_W-1:0]   m_out_base;
    perm_t             m_perm;
    logic              fin_hit;
    logic              fin_miss;

    iotlb_walk_fsm u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_req      (lk_req),
        .lk_asid     (lk_asid),
        .lk_addr     (lk_addr),
        .lk_gran     (lk_gran),
        .lk_tsz      (lk_tsz),
        .lk_write    (lk_write),
        .lk_busy     (lk_busy),
        .lk_done     (lk_done),
        .lk_hit      (lk_hit),
        .lk_fault    (lk_fault),
        .lk_out_addr (lk_out_addr),
        .lk_perm     (lk_perm),
        .probe_asid  (probe_asid),
        .probe_base  (probe_base),
        .probe_gran  (probe_gran),
        .probe_level (probe_level),
        .m_any       (m_any),
        .m_out_base  (m_out_base),
        .m_perm      (m_perm),
        .fin_hit     (fin_hit),
        .fin_miss    (fin_miss)
    );

    iotlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .ins_valid    (ins_valid),
        .ins_asid     (ins_asid),
        .ins_in_base  (ins_in_base),
        .ins_out_base (ins_out_base),
        .ins_gran     (ins_gran),
        .ins_level    (ins_level),
        .ins_perm     (ins_perm),
        .inv_all      (inv_all),
        .inv_asid_en  (inv_asid_en),
        .inv_asid     (inv_asid),
        .inv_va_en    (inv_va_en),
        .inv_va_any   (inv_va_any),
        .inv_va_asid  (inv_va_asid),
        .inv_va_addr  (inv_va_addr),
        .probe_asid   (probe_asid),
        .probe_base   (probe_base),
        .probe_gran   (probe_gran),
        .probe_level  (probe_level),
        .m_any        (m_any),
        .m_out_base   (m_out_base),
        .m_perm       (m_perm)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_cnt  <= '0;
            miss_cnt <= '0;
        end else begin
            if (fin_hit)  hit_cnt  <= hit_cnt + CNT_W'(1);
            if (fin_miss) miss_cnt <= miss_cnt + CNT_W'(1);
        end
    end

    a_r12_hit_counts: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (hit_cnt != '0));

    a_r12_miss_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && !lk_hit && !lk_fault) |-> (miss_cnt != '0));

endmodule

// File: tb/iotlb_top_tb.sv
module iotlb_top_tb_top;

    localparam int NE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [15:0] lk_asid = '0;
    logic [47:0] lk_addr = '0;
    logic [1:0]  lk_gran = '0;
    logic [5:0]  lk_tsz = '0;
    logic        lk_write = 1'b0;
    logic        lk_busy, lk_done, lk_hit, lk_fault;
    logic [47:0] lk_out_addr;
    logic [1:0]  lk_perm;
    logic        ins_valid = 1'b0;
    logic [15:0] ins_asid = '0;
    logic [47:0] ins_in_base = '0;
    logic [47:0] ins_out_base = '0;
    logic [1:0]  ins_gran = '0;
    logic [1:0]  ins_level = '0;
    logic [1:0]  ins_perm = '0;
    logic        inv_all = 1'b0;
    logic        inv_asid_en = 1'b0;
    logic [15:0] inv_asid = '0;
    logic        inv_va_en = 1'b0;
    logic        inv_va_any = 1'b0;
    logic [15:0] inv_va_asid = '0;
    logic [47:0] inv_va_addr = '0;
    logic [15:0] hit_cnt, miss_cnt;

    always #5 clk = ~clk;

    iotlb_top #(.ENTRIES(NE), .CNT_W(16)) dut_i (.*);

    int checks = 0;
    int errors = 0;

    // behavioural reference: a flat list of live mappings
    bit          m_v   [NE];
    logic [15:0] m_as  [NE];
    logic [47:0] m_in  [NE];
    logic [47:0] m_out [NE];
    int          m_g   [NE];
    int          m_l   [NE];
    logic [1:0]  m_p   [NE];
    int          exp_hits = 0;
    int          exp_miss = 0;

    function automatic logic [47:0] span_mask(int g, int l);
        int gs;
        int sh;
        gs = 10 + 2 * g;
        sh = gs + (gs - 3) * (3 - l);
        if (sh >= 48) return '1;
        return (48'd1 << sh) - 48'd1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic insert(input logic [15:0] a, input logic [47:0] ib, input logic [47:0] ob,
                          input int g, input int l, input logic [1:0] p);
        int cnt;
        int slot;
        cnt = 0;
        for (int i = 0; i < NE; i++) if (m_v[i]) cnt++;
        if (cnt == NE) for (int i = 0; i < NE; i++) m_v[i] = 0;
        slot = -1;
        for (int i = 0; i < NE; i++) if (!m_v[i] && slot < 0) slot = i;
        m_v[slot] = 1; m_as[slot] = a; m_in[slot] = ib & ~span_mask(g, l);
        m_out[slot] = ob & ~span_mask(g, l); m_g[slot] = g; m_l[slot] = l; m_p[slot] = p;
        @(negedge clk);
        ins_valid = 1; ins_asid = a; ins_in_base = ib; ins_out_base = ob;
        ins_gran = 2'(g); ins_level = 2'(l); ins_perm = p;
        @(negedge clk);
        ins_valid = 0;
    endtask

    task automatic flush_va(input bit any, input logic [15:0] a, input logic [47:0] va);
        for (int i = 0; i < NE; i++)
            if (m_v[i] && (any || m_as[i] == a) && ((va & ~span_mask(m_g[i], m_l[i])) == m_in[i]))
                m_v[i] = 0;
        @(negedge clk);
        inv_va_en = 1; inv_va_any = any; inv_va_asid = a; inv_va_addr = va;
        @(negedge clk);
        inv_va_en = 0; inv_va_any = 0;
    endtask

    task automatic flush_asid(input logic [15:0] a);
        for (int i = 0; i < NE; i++) if (m_v[i] && m_as[i] == a) m_v[i] = 0;
        @(negedge clk);
        inv_asid_en = 1; inv_asid = a;
        @(negedge clk);
        inv_asid_en = 0;
    endtask

    task automatic flush_all();
        for (int i = 0; i < NE; i++) m_v[i] = 0;
        @(negedge clk);
        inv_all = 1;
        @(negedge clk);
        inv_all = 0;
    endtask

    task automatic look(input logic [15:0] a, input logic [47:0] va, input int g,
                        input int tsz, input bit wr, input string req);
        int st;
        int n;
        int cyc;
        bit found;
        bit e_hit;
        bit e_flt;
        logic [47:0] e_out;
        logic [1:0]  e_perm;
        st = 4 - ((64 - tsz) - 4) / (7 + 2 * g);
        if (st < 0) st = 0;
        if (st > 3) st = 3;
        found = 0; n = 0; e_out = '0; e_perm = '0;
        for (int l = st; l <= 3; l++) begin
            if (!found) begin
                n++;
                for (int i = 0; i < NE; i++) begin
                    if (!found && m_v[i] && m_as[i] == a && m_g[i] == g && m_l[i] == l
                        && m_in[i] == (va & ~span_mask(g, l))) begin
                        found  = 1;
                        e_perm = m_p[i];
                        e_out  = m_out[i] + (va & span_mask(g, l));
                    end
                end
            end
        end
        e_flt = found && wr && !e_perm[1];
        e_hit = found && !e_flt;
        if (!e_hit) e_out = '0;
        if (!found) e_perm = '0;
        if (found) exp_hits++; else exp_miss++;
        @(negedge clk);
        lk_req = 1; lk_asid = a; lk_addr = va; lk_gran = 2'(g); lk_tsz = 6'(tsz); lk_write = wr;
        @(negedge clk);
        lk_req = 0;
        cyc = 1;
        while (!lk_done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == n + 1, req, "latency", 64'(cyc), 64'(n + 1));
        chk(lk_hit == e_hit, req, "hit", 64'(lk_hit), 64'(e_hit));
        chk(lk_fault == e_flt, req, "fault", 64'(lk_fault), 64'(e_flt));
        chk(lk_out_addr == e_out, req, "out_addr", 64'(lk_out_addr), 64'(e_out));
        if (e_hit) chk(lk_perm == e_perm, req, "perm", 64'(lk_perm), 64'(e_perm));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NE; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!lk_busy && !lk_done, "R4", "reset idle", 64'({lk_busy, lk_done}), 64'd0);
        chk(hit_cnt == 0 && miss_cnt == 0, "R12", "reset counters", 64'({hit_cnt, miss_cnt}), 64'd0);
        look(16'd5, 48'h1234_5678, 1, 16, 0, "R7");

        // R5 R4: 4K page found after four probes
        insert(16'd5, 48'h1234_5000, 48'hABCD_E000, 1, 3, 2'b11);
        look(16'd5, 48'h1234_5678, 1, 16, 0, "R5");
        // R2: 2 MB block at level 2
        insert(16'd5, 48'h4000_0000, 48'h8020_0000, 1, 2, 2'b01);
        look(16'd5, 48'h4012_34AB, 1, 16, 0, "R2");
        // R6: write to read-only block
        look(16'd5, 48'h4012_34AB, 1, 16, 1, "R6");
        // R3: 1 GB block with start level 1
        insert(16'd7, 48'hC000_0000, 48'h1_0000_0000, 1, 1, 2'b11);
        look(16'd7, 48'hC123_4567, 1, 25, 0, "R3");
        // R3: level 0 entry found from level 0, skipped from level 1
        insert(16'd7, 48'h80_0000_0000, 48'h0, 1, 0, 2'b11);
        look(16'd7, 48'h80_0000_1000, 1, 16, 0, "R3");
        look(16'd7, 48'h80_0000_1000, 1, 25, 0, "R3");
        // R1: 16K granule block, and the same address with another granule and ASID
        insert(16'd9, 48'h0200_0000, 48'h0600_0000, 2, 2, 2'b11);
        look(16'd9, 48'h0234_5678, 2, 28, 0, "R1");
        look(16'd9, 48'h0234_5678, 1, 16, 0, "R1");
        look(16'd8, 48'h0234_5678, 2, 28, 0, "R1");
        // R2: 64K granule level 2 block, two start levels
        insert(16'd9, 48'h2000_0000, 48'h4000_0000, 3, 2, 2'b11);
        look(16'd9, 48'h2ABC_DEF0, 3, 22, 0, "R2");
        look(16'd9, 48'h2ABC_DEF0, 3, 16, 0, "R4");

        // R9: address flush by containment, ASID-specific and wildcard
        flush_va(0, 16'd6, 48'h1234_5000);
        look(16'd5, 48'h1234_5678, 1, 16, 0, "R9");
        flush_va(0, 16'd5, 48'h4010_0000);
        look(16'd5, 48'h4012_34AB, 1, 16, 0, "R9");
        look(16'd5, 48'h1234_5678, 1, 16, 0, "R9");
        flush_va(1, 16'd0, 48'hC000_1000);
        look(16'd7, 48'hC123_4567, 1, 25, 0, "R9");
        look(16'd7, 48'h80_0000_1000, 1, 16, 0, "R9");
        // R10
        flush_asid(16'd9);
        look(16'd9, 48'h2ABC_DEF0, 3, 22, 0, "R10");
        look(16'd9, 48'h0234_5678, 2, 28, 0, "R10");
        look(16'd7, 48'h80_0000_1000, 1, 16, 0, "R10");
        // R11
        flush_all();
        look(16'd5, 48'h1234_5678, 1, 16, 0, "R11");
        look(16'd7, 48'h80_0000_1000, 1, 16, 0, "R11");

        // R8: fill to capacity, then one more
        for (int i = 0; i < NE; i++)
            insert(16'd3, 48'(i) << 12, 48'h9_0000_0000 + (48'(i) << 12), 1, 3, 2'b11);
        look(16'd3, 48'h0000_0010, 1, 16, 0, "R8");
        insert(16'd3, 48'h0100_0000, 48'h7700_0000, 1, 3, 2'b11);
        look(16'd3, 48'h0000_0010, 1, 16, 0, "R8");
        look(16'd3, 48'h0100_0ABC, 1, 16, 0, "R8");

        repeat (3) @(negedge clk);
        chk(hit_cnt == 16'(exp_hits), "R12", "hit_cnt", 64'(hit_cnt), 64'(exp_hits));
        chk(miss_cnt == 16'(exp_miss), "R12", "miss_cnt", 64'(miss_cnt), 64'(exp_miss));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule